// File: doc/BRIEF.md
# I2C Bus Master with Register Control

This block is a single-channel I2C bus master. The host programs it through a small 32-bit register file on a plain read/write bus. There is one write strobe and one read strobe, and read data comes back in the same cycle as the address. The core drives the bus only through open-drain pull-down enables for SCL and SDA. It watches the real line levels through synchronisers.

The host runs a transfer by setting and clearing control bits:

- Setting the start bit issues a START.
- Each write to the data register shifts one byte out, and the slave's acknowledge is kept for the host to read.
- Setting the repeated-start bit makes the next data write begin with a repeated START.
- Clearing the start bit issues a STOP.
- In receive mode, each read of the data register returns the byte held in the shifter and launches the next receive. The first such read after the address phase is therefore a dummy read.

A completed byte or lost arbitration sets sticky status flags and can raise an interrupt. A bus-busy flag follows the START and STOP conditions seen on the lines. A soft-reset register holds the rest of the core in reset.

None of the interfaces is a stream, so there is no valid/ready handshake. The host paces itself by polling the completion flag or waiting for the interrupt. Data accesses that arrive while the byte engine cannot take them are dropped.

Top module: `i2cm_top`

## Requirements
- R1: After rst_n, and for as long as bit 0 of the soft-reset register (offset 0xFC) is 1, the control, status and rate registers read 0 and both line enables are 0 (released). Writes to control while soft reset is held have no effect, and writing 0 to 0xFC releases the core.
- R2: When control bit 7 (enable) and bit 5 (start) are both 1 and the bus is idle, SDA is pulled low while SCL is high, and then SCL is pulled low. With bit 7 at 0, no START occurs. Status bit 5 (busy) goes to 1 when a START is seen on the lines and back to 0 when a STOP is seen.
- R3: A write to the data register (0x0C) while the bus is owned shifts the byte out MSB first, with SDA changing only while SCL is low. SDA is released during the ninth clock, and the level sampled there is stored in status bit 0, where 1 means NACK.
- R4: At the end of every byte, status bit 7 (complete) and bit 1 (interrupt flag) are set. One SCL period lasts 8 × N clocks, where N is the rate register (0x14) and a value of 0 counts as 1.
- R5: When control bit 4 is 0 (receive), a read of the data register returns the byte last shifted and starts the next receive. The ninth clock is driven low (ACK) unless control bit 3 is 1, in which case it is released (NACK).
- R6: Clearing control bit 5 while the bus is owned and no byte is in flight produces a STOP: SDA rises while SCL is high, and both lines are then left released.
- R7: With control bit 2 set, the next data write first issues a repeated START (SDA falls while SCL is high) and then sends the byte. Bit 2 clears itself when that write is accepted.
- R8: If SDA reads low during a bit in which the master released it, status bit 4 (arbitration lost) and bit 1 are set, control bit 5 clears, and both lines are released on the same cycle.
- R9: Status bits 7, 4 and 1 clear when the status register is written with a 0 in that bit position. Writing a 1 leaves the bit unchanged.
- R10: irq is 1 while (control bit 8 AND (status bit 7 OR status bit 1)) OR (control bit 9 AND status bit 4).
- R11: A data write or read that arrives while a byte is in flight, or while the bus is not owned, starts no transfer.
- R12: The bus-monitor register (0x10) returns the synchronised SCL level in bit 0 and SDA in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle (side effect on data register) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:

- The rate register is not rewritten while a byte is in flight.
- The host never writes the control and data registers in the same cycle.
- An external agent pulls SDA low only as a slave would, changing it while SCL is low, or during the deliberate arbitration episode.

The bench keeps to these rules. Its slave model changes SDA only on SCL falling edges, and the bench sets the rate once before any transfer. Every register access is a single strobe driven at the falling clock edge. The contending pull-down used to force a lost arbitration is applied while SCL is held low and removed while the bus is idle.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  // register byte offsets (host software depends on these)
  localparam logic [7:0] OFS_CTRL = 8'h04;
  localparam logic [7:0] OFS_STAT = 8'h08;
  localparam logic [7:0] OFS_DATA = 8'h0C;
  localparam logic [7:0] OFS_MON  = 8'h10;
  localparam logic [7:0] OFS_RATE = 8'h14;
  localparam logic [7:0] OFS_SRST = 8'hFC;

  // control bit positions
  localparam int CB_FAST = 0;
  localparam int CB_RSTA = 2;
  localparam int CB_NACK = 3;
  localparam int CB_TX   = 4;
  localparam int CB_STA  = 5;
  localparam int CB_EN   = 7;
  localparam int CB_IED  = 8;
  localparam int CB_IEA  = 9;
  localparam int CTRL_W  = 10;

  // status bit positions
  localparam int SB_ACK  = 0;
  localparam int SB_MIF  = 1;
  localparam int SB_AL   = 4;
  localparam int SB_BUSY = 5;
  localparam int SB_CF   = 7;

  typedef enum logic [2:0] {
    E_IDLE, E_START, E_HOLD, E_RSTART, E_XFER, E_STOP
  } eng_state_t;
endpackage

// File: rtl/i2cm_line_mon.sv
module i2cm_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic busy
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      sda_d  <= 1'b1;
      busy   <= 1'b0;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      sda_d  <= sda_s;
      if (scl_s && sda_d && !sda_s)      busy <= 1'b1;  // START seen
      else if (scl_s && !sda_d && sda_s) busy <= 1'b0;  // STOP seen
    end
  end

  assign scl_s = scl_sh[SYNC_STAGES-1];
  assign sda_s = sda_sh[SYNC_STAGES-1];
endmodule

// File: rtl/i2cm_byte_engine.sv
module i2cm_byte_engine
  import i2cm_pkg::*;
#(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_tx,
  input  logic              cmd_rx,
  input  logic              rep,
  input  logic              nack,
  input  logic [7:0]        tx_byte,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              ready,
  output logic              idle,
  output logic              done,
  output logic              al,
  output logic              ack_in,
  output logic [7:0]        shreg,
  output eng_state_t        st
);
  localparam int QW = RATE_W + 1;

  logic [1:0]        ph;
  logic [QW-1:0]     qcnt;
  logic [3:0]        bitn;
  logic              is_tx, nack_q, samp;
  logic              scl_hi, sda_hi, bit_val, tick;
  logic [RATE_W-1:0] rate_eff;
  logic [QW-1:0]     q_last;

  // a quarter of an SCL period is 2*N clocks, so a full period is 8*N
  assign rate_eff = (rate == '0) ? {{(RATE_W-1){1'b0}}, 1'b1} : rate;
  assign q_last   = {rate_eff, 1'b0} - 1'b1;
  assign tick     = (qcnt == q_last);

  assign bit_val = (bitn == 4'd8) ? (is_tx ? 1'b1 : nack_q)
                                  : (is_tx ? shreg[7] : 1'b1);

  always_comb begin
    scl_hi = 1'b1;
    sda_hi = 1'b1;
    unique case (st)
      E_START:  begin scl_hi = !ph[1];                    sda_hi = (ph == 2'd0); end
      E_HOLD:   begin scl_hi = 1'b0;                      sda_hi = 1'b0;         end
      E_RSTART: begin scl_hi = (ph == 2'd1) || (ph == 2'd2); sda_hi = !ph[1];    end
      E_XFER:   begin scl_hi = (ph == 2'd1) || (ph == 2'd2); sda_hi = bit_val;   end
      E_STOP:   begin scl_hi = (ph != 2'd0);              sda_hi = ph[1];        end
      default:  ;
    endcase
  end

  assign scl_oe = !scl_hi;
  assign sda_oe = !sda_hi;
  assign ready  = (st == E_HOLD);
  assign idle   = (st == E_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= E_IDLE;  ph <= '0;  qcnt <= '0;  bitn <= '0;
      is_tx <= 1'b0; nack_q <= 1'b0; samp <= 1'b1; shreg <= '0;
      ack_in <= 1'b0; done <= 1'b0; al <= 1'b0;
    end else begin
      done <= 1'b0;
      al   <= 1'b0;
      if (st == E_IDLE) begin
        if (cmd_start) begin st <= E_START; ph <= '0; qcnt <= '0; end
      end else if (st == E_HOLD) begin
        ph <= '0; qcnt <= '0; bitn <= '0;
        if (cmd_stop) st <= E_STOP;
        else if (cmd_tx) begin
          shreg <= tx_byte; is_tx <= 1'b1;
          st <= rep ? E_RSTART : E_XFER;
        end else if (cmd_rx) begin
          is_tx <= 1'b0; nack_q <= nack; st <= E_XFER;
        end
      end else if (!tick) begin
        qcnt <= qcnt + 1'b1;
      end else begin
        qcnt <= '0;
        ph   <= ph + 2'd1;
        if (st == E_XFER && ph == 2'd2) begin
          samp <= sda_in;
          if (bitn == 4'd8 && is_tx) ack_in <= sda_in;
        end
        if (st == E_XFER && ph == 2'd2 && bitn != 4'd8 && is_tx && shreg[7] && !sda_in) begin
          st <= E_IDLE;
          al <= 1'b1;
        end else if (ph == 2'd3) begin
          unique case (st)
            E_START:  st <= E_HOLD;
            E_RSTART: st <= E_XFER;
            E_STOP:   st <= E_IDLE;
            E_XFER: begin
              if (bitn == 4'd8) begin
                st <= E_HOLD; done <= 1'b1;
              end else begin
                shreg <= {shreg[6:0], samp};
                bitn  <= bitn + 4'd1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2cm_top.sv
module i2cm_top
  import i2cm_pkg::*;
#(
  parameter int RATE_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        scl_oe,
  output logic        sda_oe,
  output logic        irq
);
  logic              srst, core_rst_n;
  logic [CTRL_W-1:0] ctrl;
  logic [RATE_W-1:0] rate;
  logic              st_cf, st_al, st_mif;
  logic              scl_s, sda_s, bus_busy;
  logic              eng_ready, eng_idle, eng_done, eng_al, eng_ack;
  logic [7:0]        eng_byte;
  eng_state_t        eng_st;
  logic              wr_ctrl, wr_stat, wr_rate, cmd_start, cmd_tx, cmd_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) srst <= 1'b0;
    else if (reg_wr && reg_addr == OFS_SRST) srst <= reg_wdata[0];
  end
  assign core_rst_n = rst_n & ~srst;

  assign wr_ctrl   = reg_wr && reg_addr == OFS_CTRL;
  assign wr_stat   = reg_wr && reg_addr == OFS_STAT;
  assign wr_rate   = reg_wr && reg_addr == OFS_RATE;
  assign cmd_tx    = reg_wr && reg_addr == OFS_DATA;
  assign cmd_rx    = reg_rd && reg_addr == OFS_DATA && !ctrl[CB_TX];
  assign cmd_start = ctrl[CB_EN] && ctrl[CB_STA] && eng_idle && !eng_al;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      ctrl <= '0; rate <= '0;
      st_cf <= 1'b0; st_al <= 1'b0; st_mif <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= reg_wdata[CTRL_W-1:0];
      else if (cmd_tx && eng_ready && ctrl[CB_STA] && ctrl[CB_RSTA]) ctrl[CB_RSTA] <= 1'b0;
      if (eng_al) ctrl[CB_STA] <= 1'b0;
      if (wr_rate) rate <= reg_wdata[RATE_W-1:0];
      if (wr_stat) begin
        st_cf  <= st_cf  & reg_wdata[SB_CF];
        st_al  <= st_al  & reg_wdata[SB_AL];
        st_mif <= st_mif & reg_wdata[SB_MIF];
      end
      if (eng_done) begin st_cf <= 1'b1; st_mif <= 1'b1; end
      if (eng_al)   begin st_al <= 1'b1; st_mif <= 1'b1; end
    end
  end

  i2cm_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(core_rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .busy(bus_busy)
  );

  i2cm_byte_engine #(.RATE_W(RATE_W)) u_eng (
    .clk(clk), .rst_n(core_rst_n), .rate(rate),
    .cmd_start(cmd_start), .cmd_stop(!ctrl[CB_STA]), .cmd_tx(cmd_tx), .cmd_rx(cmd_rx),
    .rep(ctrl[CB_RSTA]), .nack(ctrl[CB_NACK]), .tx_byte(reg_wdata[7:0]),
    .sda_in(sda_s), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .ready(eng_ready), .idle(eng_idle), .done(eng_done), .al(eng_al),
    .ack_in(eng_ack), .shreg(eng_byte), .st(eng_st)
  );

  assign irq = (ctrl[CB_IED] && (st_cf || st_mif)) || (ctrl[CB_IEA] && st_al);

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_CTRL: reg_rdata[CTRL_W-1:0] = ctrl;
      OFS_STAT: begin
        reg_rdata[SB_CF]   = st_cf;
        reg_rdata[SB_BUSY] = bus_busy;
        reg_rdata[SB_AL]   = st_al;
        reg_rdata[SB_MIF]  = st_mif;
        reg_rdata[SB_ACK]  = eng_ack;
      end
      OFS_DATA: reg_rdata[7:0] = eng_byte;
      OFS_MON:  reg_rdata[1:0] = {sda_s, scl_s};
      OFS_RATE: reg_rdata[RATE_W-1:0] = rate;
      OFS_SRST: reg_rdata[0] = srst;
      default:  ;
    endcase
  end
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker
  import i2cm_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       core_rst_n,
  input logic       srst,
  input logic       scl_oe,
  input logic       sda_oe,
  input eng_state_t eng_st,
  input logic       eng_done,
  input logic       eng_al,
  input logic       st_cf,
  input logic       st_mif,
  input logic       ctrl_sta
);
  // R1: soft reset keeps both lines released
  p_srst_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    srst |-> (!scl_oe && !sda_oe));

  // R3: inside a byte, SDA only moves while SCL is pulled low
  p_sda_hold_r3: assert property (@(posedge clk) disable iff (!core_rst_n)
    (eng_st == E_XFER && $past(eng_st) == E_XFER && !$past(scl_oe)) |-> $stable(sda_oe));

  // R4: byte completion lands in the status flags
  p_done_flags_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    eng_done |=> (st_cf && st_mif));

  // R8: losing arbitration releases both lines at once
  p_al_release_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    eng_al |-> (!scl_oe && !sda_oe));

  // R8: losing arbitration drops the start request
  p_al_drops_start_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    eng_al |=> !ctrl_sta);

  // R8: a byte cannot both complete and lose arbitration
  p_done_al_excl_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(eng_done && eng_al));
endmodule

bind i2cm_top i2cm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .core_rst_n(core_rst_n), .srst(srst),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .eng_st(eng_st),
  .eng_done(eng_done), .eng_al(eng_al), .st_cf(st_cf), .st_mif(st_mif),
  .ctrl_sta(ctrl[5])
);

// File: tb/i2cm_top_bench.sv
`timescale 1ns/1ps
module i2cm_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        scl_oe, sda_oe, irq;
  logic        scl_line, sda_line;
  logic        slv_low = 1'b0, arb_low = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | slv_low | arb_low);

  i2cm_top u_i2cm_top (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
  );

  // ---------------- slave model, acts on falling clock edges ----------------
  logic       ps = 1'b1, pd = 1'b1;
  int         bitc = 0, nbytes = 0, nstarts = 0, nstops = 0;
  logic [7:0] rcv = '0, got = '0, stx = 8'hC3;
  logic       is_addr = 1'b0, rdmode = 1'b0, mack = 1'b0, ack_en = 1'b1;
  int         cyc = 0, last_rise = 0, period = 0;

  always @(negedge clk) begin
    cyc++;
    if (ps && scl_line && pd && !sda_line) begin
      nstarts++; bitc = 0; is_addr = 1'b1; rdmode = 1'b0; slv_low = 1'b0;
    end else if (ps && scl_line && !pd && sda_line) begin
      nstops++; rdmode = 1'b0; slv_low = 1'b0;
    end else if (!ps && scl_line) begin
      period = cyc - last_rise; last_rise = cyc;
      if (bitc < 8) begin rcv = {rcv[6:0], sda_line}; bitc++; end
      else begin
        bitc = 0;
        if (rdmode) begin
          mack = sda_line; stx = stx + 8'd1;
          if (sda_line) rdmode = 1'b0;
        end else begin
          got = rcv; nbytes++;
          if (is_addr) begin rdmode = rcv[0]; is_addr = 1'b0; end
        end
      end
    end else if (ps && !scl_line) begin
      if (bitc == 8) slv_low = !rdmode && ack_en;
      else slv_low = rdmode && !stx[7-bitc];
    end
    ps = scl_line; pd = sda_line;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_stat(input int bitpos);
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(8'h08, s);
      if (s[bitpos]) return;
    end
  endtask

  task automatic idle_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    logic [31:0] v;
    rd(8'h04, v); chk("R1 ctrl after reset", v, 0);
    rd(8'h08, v); chk("R1 status after reset", v, 0);
    chk("R1 lines released", {scl_oe, sda_oe}, 2'b00);
    rd(8'h10, v); chk("R12 monitor idle lines", v, 32'h3);
  endtask

  task automatic t_enable_gate;
    logic [31:0] v;
    wr(8'h04, 32'h320); idle_clks(40);
    chk("R2 no START without enable", scl_oe, 1'b0);
    rd(8'h08, v); chk("R2 busy stays clear", v[5], 1'b0);
    wr(8'h04, 32'h000);
  endtask

  task automatic t_write_bytes;
    logic [31:0] v; int nb;
    wr(8'h14, 32'd2);
    wr(8'h04, 32'h3B0); idle_clks(40);
    chk("R2 START holds SCL low", scl_oe, 1'b1);
    rd(8'h08, v); chk("R2 busy after START", v[5], 1'b1);
    rd(8'h10, v); chk("R12 monitor owned lines", v[1:0], 2'b00);
    wr(8'h0C, 32'hA4); wait_stat(7);
    chk("R3 slave got address", got, 8'hA4);
    rd(8'h08, v);
    chk("R3 ACK recorded", v[0], 1'b0);
    chk("R4 complete and flag", {v[7], v[1]}, 2'b11);
    chk("R4 SCL period 8N", period, 16);
    chk("R10 irq on complete", irq, 1'b1);
    wr(8'h08, 32'h0); rd(8'h08, v);
    chk("R9 write 0 clears flags", {v[7], v[1]}, 2'b00);
    chk("R10 irq drops", irq, 1'b0);
    nb = nbytes;
    wr(8'h0C, 32'h3C); wr(8'h0C, 32'h11);  // second write lands mid-byte
    wait_stat(7); idle_clks(200);
    chk("R3 second byte", got, 8'h3C);
    chk("R11 mid-byte write dropped", nbytes - nb, 1);
    wr(8'h08, 32'h0);
    ack_en = 1'b0;
    wr(8'h0C, 32'h77); wait_stat(7);
    rd(8'h08, v); chk("R3 NACK recorded", v[0], 1'b1);
    ack_en = 1'b1;
    wr(8'h08, 32'h0);
  endtask

  task automatic t_read_bytes;
    logic [31:0] v; int ns;
    ns = nstarts;
    wr(8'h04, 32'h3B4);
    wr(8'h0C, 32'hA5); wait_stat(7);
    chk("R7 repeated START seen", nstarts - ns, 1);
    rd(8'h04, v); chk("R7 bit self-clears", v[2], 1'b0);
    wr(8'h08, 32'h0);
    wr(8'h04, 32'h3A0);
    rd(8'h0C, v);                           // dummy read launches byte 1
    wait_stat(7); wr(8'h08, 32'h0);
    chk("R5 master ACKed byte", mack, 1'b0);
    wr(8'h04, 32'h3A8);
    rd(8'h0C, v); chk("R5 read returns byte", v[7:0], 8'hC3);
    wait_stat(7); wr(8'h08, 32'h0);
    chk("R5 master NACKed last", mack, 1'b1);
    ns = nstops;
    wr(8'h04, 32'h380); idle_clks(60);
    chk("R6 STOP seen", nstops - ns, 1);
    chk("R6 lines released", {scl_oe, sda_oe}, 2'b00);
    rd(8'h08, v); chk("R2 busy cleared by STOP", v[5], 1'b0);
    rd(8'h0C, v); chk("R5 final byte", v[7:0], 8'hC4);
    idle_clks(40); chk("R11 read while not owned", scl_oe, 1'b0);
  endtask

  task automatic t_arbitration;
    logic [31:0] v;
    wr(8'h04, 32'h3B0); idle_clks(40);
    arb_low = 1'b1;
    wr(8'h0C, 32'hFF); wait_stat(4);
    rd(8'h08, v); chk("R8 lost and flag", {v[4], v[1]}, 2'b11);
    rd(8'h04, v); chk("R8 start cleared", v[5], 1'b0);
    chk("R8 lines released", {scl_oe, sda_oe}, 2'b00);
    chk("R10 irq on arbitration", irq, 1'b1);
    wr(8'h08, 32'h92); rd(8'h08, v);
    chk("R9 write 1 keeps flags", {v[4], v[1]}, 2'b11);
    arb_low = 1'b0; idle_clks(10);
    wr(8'h08, 32'h0);
  endtask

  task automatic t_soft_reset;
    logic [31:0] v;
    wr(8'h04, 32'h3B0); idle_clks(40);
    wr(8'hFC, 32'h1);
    chk("R1 soft reset releases lines", {scl_oe, sda_oe}, 2'b00);
    wr(8'h04, 32'h80); rd(8'h04, v);
    chk("R1 ctrl held at 0", v, 0);
    rd(8'h14, v); chk("R1 rate cleared", v, 0);
    rd(8'hFC, v); chk("R1 soft reset reads back", v, 1);
    wr(8'hFC, 32'h0); wr(8'h04, 32'h80); rd(8'h04, v);
    chk("R1 released core writable", v, 32'h80);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable_gate();
    t_write_bytes();
    t_read_bytes();
    t_arbitration();
    t_soft_reset();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule